// File: doc/BRIEF.md
# Reloading Event Counter Timer

This block is an 8-bit up-counter that, on wrapping past its all-ones value, restarts from a software-programmed reload value rather than from zero. Each wrap sets a sticky overflow flag and, when enabled, holds an interrupt request high. The counter advances on one of two count sources: a single-cycle tick from an internal prescaler, or rising edges seen on an external event pin. Programming reload value V makes the flag set once every 256 - V counts, so in event mode the block acts as an event detector that reports after a chosen number of external events.

Software reaches the block through a small register port with three registers: control/status, reload, and the live counter value. Reads are combinational on the address. A read strobe on the control/status address acknowledges the overflow. A halt input stops the external count path, so that a pin left floating during low-power periods cannot add spurious counts.

Top module: `evt_reload_timer`

## Requirements
- R1: After reset the control/status, reload and counter registers all read zero and `irq_o` is low.
- R2: With count enable (control bit 0) set and source select (control bit 2) clear, the counter adds one on each cycle where `tick_i` is high.
- R3: A count step taken while the counter holds FFh loads the counter with the reload register (address 1) and sets the overflow flag, which reads back as control/status bit 7.
- R4: `irq_o` is high exactly while the overflow flag is set and interrupt enable (control bit 1) is set.
- R5: The overflow flag stays set until a cycle with `rd_i` high on address 0, after which it reads zero. A write to address 0 never changes the flag.
- R6: If an overflow and a clearing read of address 0 fall in the same cycle, the flag is set afterwards.
- R7: With source select set, each rising edge of `evt_i` counts exactly once, however long the pin stays high. With reload value V, the flag sets after 256 - V edges (FDh gives 3).
- R8: With count enable clear, neither source changes the counter.
- R9: While `halt_i` is high, edges on `evt_i` produce no counts.
- R10: A write to address 2 loads the counter on the next edge and takes priority over a count step in the same cycle. That step then causes no overflow.
- R11: A write to the reload register leaves the current count untouched and is used at the next overflow.
- R12: The source that is not selected has no effect: `tick_i` in event mode, `evt_i` in tick mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| halt_i | input | 1 | Low-power indication, blocks external counts |
| tick_i | input | 1 | Internal prescaled count tick, one cycle wide |
| evt_i | input | 1 | External event pin, asynchronous |
| addr_i | input | 2 | Register address: 0 control/status, 1 reload, 2 counter |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (address 0 acknowledges overflow) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Overflow interrupt request, level |

## Verification
Two pairs of actions can fall in the same cycle. An overflow can coincide with the acknowledging status read, and a counter write can coincide with a count step at FFh. The bench provokes both on purpose. It parks the counter at FFh, then asserts the tick together with either the status read or a counter write, and checks whether the flag survives and which counter value wins. A seeded random phase then mixes ticks, reads and writes freely against a cycle model, so these collisions also arise at other counter and reload values.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  typedef enum logic [1:0] {
    ADR_CTRL   = 2'd0,
    ADR_RELOAD = 2'd1,
    ADR_COUNT  = 2'd2,
    ADR_NONE   = 2'd3
  } reg_addr_e;

  localparam int CTL_EN_BIT  = 0;
  localparam int CTL_IE_BIT  = 1;
  localparam int CTL_EXT_BIT = 2;
  localparam int CTL_W       = 3;
endpackage

// File: rtl/evt_rst_sync.sv
module evt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/evt_edge_sync.sv
module evt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic halt_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= 1'b0;
          else        sync_q[s] <= evt_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= 1'b0;
          else        sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[STAGES-1];
  end

  assign edge_o = sync_q[STAGES-1] & ~last_q & ~halt_i;

  // R9: no external count leaves this block during halt
  a_r9_halt_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    halt_i |-> !edge_o);
  // R7: one pin rise yields a single-cycle pulse
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> !edge_o);
endmodule

// File: rtl/evt_step_sel.sv
module evt_step_sel (
  input  logic en_i,
  input  logic ext_i,
  input  logic tick_i,
  input  logic edge_i,
  output logic step_o
);
  logic src;

  always_comb begin
    src    = ext_i ? edge_i : tick_i;
    step_o = en_i & src;
  end
endmodule

// File: rtl/evt_count_core.sv
module evt_count_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic [W-1:0] reload_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o,
  output logic         flag_o
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
  localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_n;
  logic         flag_q, flag_n;
  logic         ovf;

  always_comb begin
    ovf   = step_i & ~ld_i & (cnt_q == CNT_MAX);
    cnt_n = cnt_q;
    if (ld_i)        cnt_n = ld_val_i;
    else if (ovf)    cnt_n = reload_i;
    else if (step_i) cnt_n = cnt_q + ONE;
    flag_n = flag_q;
    if (ovf)         flag_n = 1'b1;
    else if (clr_i)  flag_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      flag_q <= flag_n;
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;

  // R2: a plain step adds one
  a_r2_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !ld_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + ONE);
  // R3: a step at the top value reloads and flags
  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !ld_i && cnt_q == CNT_MAX) |=> (cnt_q == $past(reload_i)) && flag_q);
  // R5: an acknowledge without a new overflow clears
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !(step_i && !ld_i && cnt_q == CNT_MAX)) |=> !flag_q);
  // R6: overflow wins over a same-cycle acknowledge
  a_r6_keep_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && step_i && !ld_i && cnt_q == CNT_MAX) |=> flag_q);
  // R10: a direct load is taken as written
  a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> cnt_q == $past(ld_val_i));
endmodule

// File: rtl/evt_reload_timer.sv
module evt_reload_timer
  import evt_timer_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         halt_i,
  input  logic         tick_i,
  input  logic         evt_i,
  input  logic [1:0]   addr_i,
  input  logic         wr_i,
  input  logic         rd_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  output logic         irq_o
);
  localparam int PAD_W = W - CTL_W - 1;

  logic              rst_n_s;
  logic [CTL_W-1:0]  ctl_q, ctl_n;
  logic [W-1:0]      reload_q, reload_n;
  logic [W-1:0]      cnt;
  logic              flag;
  logic              ext_edge;
  logic              step;
  logic              cnt_ld;
  logic              flag_clr;
  reg_addr_e         addr;

  evt_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  evt_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .evt_i  (evt_i),
    .halt_i (halt_i),
    .edge_o (ext_edge)
  );

  evt_step_sel u_sel (
    .en_i   (ctl_q[CTL_EN_BIT]),
    .ext_i  (ctl_q[CTL_EXT_BIT]),
    .tick_i (tick_i),
    .edge_i (ext_edge),
    .step_o (step)
  );

  evt_count_core #(.W(W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .step_i   (step),
    .ld_i     (cnt_ld),
    .ld_val_i (wdata_i),
    .reload_i (reload_q),
    .clr_i    (flag_clr),
    .cnt_o    (cnt),
    .flag_o   (flag)
  );

  always_comb begin
    addr     = reg_addr_e'(addr_i);
    cnt_ld   = wr_i && (addr == ADR_COUNT);
    flag_clr = rd_i && (addr == ADR_CTRL);
    ctl_n    = ctl_q;
    reload_n = reload_q;
    if (wr_i && addr == ADR_CTRL)   ctl_n    = wdata_i[CTL_W-1:0];
    if (wr_i && addr == ADR_RELOAD) reload_n = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ctl_q    <= '0;
      reload_q <= '0;
    end else begin
      ctl_q    <= ctl_n;
      reload_q <= reload_n;
    end
  end

  always_comb begin
    case (addr)
      ADR_CTRL:   rdata_o = {flag, {PAD_W{1'b0}}, ctl_q};
      ADR_RELOAD: rdata_o = reload_q;
      ADR_COUNT:  rdata_o = cnt;
      default:    rdata_o = '0;
    endcase
  end

  assign irq_o = flag & ctl_q[CTL_IE_BIT];

  // R8: a disabled counter only moves by direct write
  a_r8_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!ctl_q[CTL_EN_BIT] && !cnt_ld) |=> $stable(cnt));
  // R12: in tick mode the event pin cannot move the counter
  a_r12_tick_mode_pin: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!ctl_q[CTL_EXT_BIT] && !tick_i && !cnt_ld) |=> $stable(cnt));
  // R4: a raised request implies a set flag
  a_r4_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_o |-> flag);
endmodule

// File: tb/evt_reload_timer_test.sv
`timescale 1ns/1ps
module evt_reload_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       halt_i = 1'b0;
  logic       tick_i = 1'b0;
  logic       evt_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic       wr_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  evt_reload_timer uut (
    .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .tick_i(tick_i), .evt_i(evt_i),
    .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); wr_i = 0; rd_i = 0; tick_i = 0;
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_i = 1; rd_i = 0; tick_i = 0; addr_i = a; wdata_i = d;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); wr_i = 0; rd_i = 0; tick_i = 1;
    end
  endtask

  task automatic rdclr();
    @(negedge clk); wr_i = 0; rd_i = 1; tick_i = 0; addr_i = 2'd0;
  endtask

  task automatic peek(input logic [1:0] a, input logic [7:0] e, input string tag);
    @(negedge clk); wr_i = 0; rd_i = 0; tick_i = 0; addr_i = a;
    #1 chk(tag, rdata_o, e);
  endtask

  task automatic peek_irq(input logic e, input string tag);
    @(negedge clk); wr_i = 0; rd_i = 0; tick_i = 0;
    #1 chk(tag, irq_o, e);
  endtask

  task automatic evpulse(input int high);
    @(negedge clk); wr_i = 0; rd_i = 0; tick_i = 0; evt_i = 1;
    idle(high);
    @(negedge clk); evt_i = 0;
    idle(4);
  endtask

  // cycle model used by the random phase
  logic [7:0] m_cnt, m_rld;
  logic [2:0] m_ctl;
  logic       m_flag;

  function automatic logic [7:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return {m_flag, 4'b0000, m_ctl};
      2'd1: return m_rld;
      2'd2: return m_cnt;
      default: return 8'h00;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    idle(3);
    // R1 reset state, observed while reset is held
    peek(2'd0, 8'h00, "R1 ctrl");
    peek(2'd1, 8'h00, "R1 reload");
    peek(2'd2, 8'h00, "R1 count");
    peek_irq(1'b0, "R1 irq");
    @(negedge clk); rst_n = 1;
    idle(4);
    peek(2'd2, 8'h00, "R1 count after release");

    // R2 counting on internal ticks
    wreg(2'd0, 8'h01);
    ticks(5);
    peek(2'd2, 8'h05, "R2 five ticks");

    // R3 / R4 overflow reload and request
    wreg(2'd1, 8'h10);
    wreg(2'd2, 8'hFE);
    wreg(2'd0, 8'h03);
    ticks(2);
    peek(2'd2, 8'h10, "R3 reload value");
    peek(2'd0, 8'h83, "R3 flag set");
    peek_irq(1'b1, "R4 irq high");
    // R5 acknowledge and write immunity
    rdclr();
    peek(2'd0, 8'h03, "R5 cleared by read");
    peek_irq(1'b0, "R4 irq low");
    wreg(2'd0, 8'h83);
    peek(2'd0, 8'h03, "R5 write leaves flag");
    wreg(2'd2, 8'hFF);
    ticks(1);
    idle(5);
    peek(2'd0, 8'h83, "R5 sticky");

    // R6 overflow with same-cycle acknowledge
    wreg(2'd2, 8'hFF);
    @(negedge clk); wr_i = 0; rd_i = 1; tick_i = 1; addr_i = 2'd0;
    peek(2'd0, 8'h83, "R6 flag kept");
    peek(2'd2, 8'h10, "R6 reload");
    rdclr();
    peek(2'd0, 8'h03, "R6 later clear");

    // R11 reload update takes effect at next overflow
    wreg(2'd2, 8'hF0);
    ticks(3);
    wreg(2'd1, 8'h40);
    peek(2'd2, 8'hF3, "R11 count untouched");
    ticks(12);
    peek(2'd2, 8'hFF, "R11 at top");
    ticks(1);
    peek(2'd2, 8'h40, "R11 new reload used");
    rdclr();

    // R10 write wins over step
    @(negedge clk); wr_i = 1; rd_i = 0; tick_i = 1; addr_i = 2'd2; wdata_i = 8'h22;
    peek(2'd2, 8'h22, "R10 write over step");
    wreg(2'd2, 8'hFF);
    @(negedge clk); wr_i = 1; rd_i = 0; tick_i = 1; addr_i = 2'd2; wdata_i = 8'h55;
    peek(2'd2, 8'h55, "R10 write at top");
    peek(2'd0, 8'h03, "R10 no overflow");

    // R8 disabled
    wreg(2'd0, 8'h02);
    ticks(4);
    peek(2'd2, 8'h55, "R8 no count when disabled");

    // R7 event mode
    wreg(2'd1, 8'hFD);
    wreg(2'd2, 8'hFD);
    wreg(2'd0, 8'h07);
    evpulse(2);
    evpulse(2);
    peek(2'd2, 8'hFF, "R7 two events");
    peek(2'd0, 8'h07, "R7 no flag after two");
    evpulse(2);
    peek(2'd2, 8'hFD, "R7 third event reloads");
    peek(2'd0, 8'h87, "R7 flag after three");
    peek_irq(1'b1, "R7 irq");
    rdclr();
    evpulse(12);
    peek(2'd2, 8'hFE, "R7 long high counts once");
    wreg(2'd2, 8'hFD);

    // R12 tick ignored in event mode
    ticks(5);
    peek(2'd2, 8'hFD, "R12 tick ignored");

    // R9 halt blocks events
    halt_i = 1;
    evpulse(2);
    evpulse(2);
    evpulse(2);
    peek(2'd2, 8'hFD, "R9 halted count");
    peek(2'd0, 8'h07, "R9 halted flag");
    halt_i = 0;
    idle(3);
    peek(2'd2, 8'hFD, "R9 after halt");

    // R12 pin ignored in tick mode
    wreg(2'd0, 8'h03);
    evpulse(2);
    evpulse(2);
    peek(2'd2, 8'hFD, "R12 pin ignored");

    // random phase against a cycle model
    @(negedge clk); rst_n = 0; wr_i = 0; rd_i = 0; tick_i = 0;
    idle(2);
    @(negedge clk); rst_n = 1;
    idle(4);
    m_cnt = 8'h00; m_rld = 8'h00; m_ctl = 3'b000; m_flag = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      logic       w, r, tk, ld, stp, ovf;
      logic [1:0] a;
      logic [7:0] d;
      w  = ($urandom % 5) == 0;
      r  = ($urandom % 3) == 0;
      tk = $urandom % 2;
      a  = 2'($urandom % 4);
      d  = 8'($urandom);
      if (($urandom % 4) == 0) d = 8'hFF;
      @(negedge clk);
      wr_i = w; rd_i = r; tick_i = tk; addr_i = a; wdata_i = d;
      halt_i = $urandom % 2;
      #1;
      chk("R4 random irq", irq_o, m_flag & m_ctl[1]);
      chk("R2 R3 R5 R6 R10 random read", rdata_o, m_read(a));
      @(posedge clk);
      ld  = w && a == 2'd2;
      stp = m_ctl[0] && !m_ctl[2] && tk;
      ovf = stp && !ld && m_cnt == 8'hFF;
      if (ld)       m_cnt = d;
      else if (ovf) m_cnt = m_rld;
      else if (stp) m_cnt = m_cnt + 8'h01;
      if (ovf)                  m_flag = 1'b1;
      else if (r && a == 2'd0)  m_flag = 1'b0;
      if (w && a == 2'd0) m_ctl = d[2:0];
      if (w && a == 2'd1) m_rld = d;
    end
    idle(2);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule